// File: doc/BRIEF.md
# Pin Invert and Override Unit

This unit stands between a controller's raw board pins and its internal logic. Every input pin passes through a multi-stage synchronizer. An invert bit set per pin then decides the polarity that the internal logic sees. The synchronized value from before the inversion stays readable, so software can look at the true board level.

Every output pin normally carries the value that the internal logic generates. Software can replace that value with its own through an override enable and an override value. The replacement takes effect only when a per-pin allow mask permits the chosen level. Output inversion is applied after this selection.

A flash write-protect output, active low, is held asserted unless software releases it through an override. Its matching input pin is synchronized for readback only and has no path to the output. A small register port with one address bus, a write strobe and a combinational read path configures the unit.

Top module: `pin_ctl_unit`

## Requirements
- R1: After reset every configuration register reads 0. `out_pin_o` then equals `int_out_i` and `wp_out_l_o` is 0.
- R2: `in_val_o[i]` equals `in_pin_i[i]` XOR the invert bit i (address 0). A change on `in_pin_i` reaches `in_val_o` after exactly SYNC_STAGES rising clock edges.
- R3: A read of address 6 returns the synchronized, non-inverted `in_pin_i` in bits N_IN-1:0 and the synchronized `wp_pin_l_i` in bit N_IN. All other bits read 0.
- R4: When override enable bit i (address 2) is set and the level in override value bit i (address 3) is allowed, the pre-inversion value of output i is that override value.
- R5: An override value of 0 takes effect only if allow-0 bit i (address 4) is set. An override value of 1 takes effect only if allow-1 bit i (address 5) is set. Otherwise `int_out_i[i]` passes through.
- R6: Output invert bit i (address 1) is applied after the override selection, so it inverts both the internal value and the override value.
- R7: `wp_out_l_o` is 1 only when bit N_OUT is set in the enable, value and allow-1 registers. Otherwise it is 0. `wp_pin_l_i` never affects it.
- R8: Addresses 0 and 1 store N_IN and N_OUT bits. Addresses 2 to 5 store N_OUT+1 bits. Unused bits read 0, and a write to address 6 changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_pin_i | input | N_IN | Raw input pins from the board |
| wp_pin_l_i | input | 1 | Raw write-protect input pin, readback only |
| in_val_o | output | N_IN | Synchronized, polarity-corrected inputs to internal logic |
| int_out_i | input | N_OUT | Output values generated by internal logic |
| out_pin_o | output | N_OUT | Output pins after override and inversion |
| wp_out_l_o | output | 1 | Flash write-protect output, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for both read and write |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Combinational read data |

## Verification
A corrupted configuration bit shows up at the pins right away. Output selection and inversion are combinational from the stored registers, so a bad enable, allow or invert bit alters `out_pin_o` or `wp_out_l_o` in the same cycle as the write. A bad synchronizer depth or bad wiring shifts the moment `in_val_o` and the raw readback follow a pin edge, and the bench samples one edge early as well as on time. Because the write-protect pin is toggled throughout the override sweep, any path from it to the output appears as a mismatch at once.

// File: rtl/pin_ctl_pkg.sv
package pin_ctl_pkg;
   typedef enum logic [2:0] {
      RA_IN_INV   = 3'd0,
      RA_OUT_INV  = 3'd1,
      RA_OVR_EN   = 3'd2,
      RA_OVR_VAL  = 3'd3,
      RA_ALLOW0   = 3'd4,
      RA_ALLOW1   = 3'd5,
      RA_RAW      = 3'd6,
      RA_SPARE    = 3'd7
   } reg_addr_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pin_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pin_sync: W must be at least 1");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[0] <= '0;
            else         stg_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
   import pin_ctl_pkg::*;
#(
   parameter int N_IN  = 4,
   parameter int N_OUT = 4,
   parameter int DW    = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [2:0]       addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [N_IN:0]    raw_i,
   output logic [N_IN-1:0]  in_inv_o,
   output logic [N_OUT-1:0] out_inv_o,
   output logic [N_OUT:0]   ovr_en_o,
   output logic [N_OUT:0]   ovr_val_o,
   output logic [N_OUT:0]   allow0_o,
   output logic [N_OUT:0]   allow1_o,
   output logic [DW-1:0]    rdata_o
);
   localparam int CW = N_OUT + 1;

   reg_addr_e addr;
   assign addr = reg_addr_e'(addr_i);

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         in_inv_o  <= '0;
         out_inv_o <= '0;
         ovr_en_o  <= '0;
         ovr_val_o <= '0;
         allow0_o  <= '0;
         allow1_o  <= '0;
      end else if (wr_i) begin
         case (addr)
            RA_IN_INV:  in_inv_o  <= wdata_i[N_IN-1:0];
            RA_OUT_INV: out_inv_o <= wdata_i[N_OUT-1:0];
            RA_OVR_EN:  ovr_en_o  <= wdata_i[CW-1:0];
            RA_OVR_VAL: ovr_val_o <= wdata_i[CW-1:0];
            RA_ALLOW0:  allow0_o  <= wdata_i[CW-1:0];
            RA_ALLOW1:  allow1_o  <= wdata_i[CW-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr)
         RA_IN_INV:  rdata_o[N_IN-1:0]  = in_inv_o;
         RA_OUT_INV: rdata_o[N_OUT-1:0] = out_inv_o;
         RA_OVR_EN:  rdata_o[CW-1:0]    = ovr_en_o;
         RA_OVR_VAL: rdata_o[CW-1:0]    = ovr_val_o;
         RA_ALLOW0:  rdata_o[CW-1:0]    = allow0_o;
         RA_ALLOW1:  rdata_o[CW-1:0]    = allow1_o;
         RA_RAW:     rdata_o[N_IN:0]    = raw_i;
         default:    rdata_o            = '0;
      endcase
   end
endmodule

// File: rtl/pin_out_mux.sv
module pin_out_mux #(
   parameter int N_OUT = 4
) (
   input  logic [N_OUT-1:0] int_out_i,
   input  logic [N_OUT-1:0] out_inv_i,
   input  logic [N_OUT:0]   ovr_en_i,
   input  logic [N_OUT:0]   ovr_val_i,
   input  logic [N_OUT:0]   allow0_i,
   input  logic [N_OUT:0]   allow1_i,
   output logic [N_OUT-1:0] out_pin_o,
   output logic             wp_out_l_o
);
   for (genvar i = 0; i <= N_OUT; i++) begin : g_ch
      logic permit;
      logic take;
      assign permit = ovr_val_i[i] ? allow1_i[i] : allow0_i[i];
      assign take   = ovr_en_i[i] & permit;
      if (i == N_OUT) begin : g_wp
         // write-protect channel: internal default is asserted (0), no pin path
         assign wp_out_l_o = take & ovr_val_i[i];
      end else begin : g_pin
         logic pre;
         assign pre          = take ? ovr_val_i[i] : int_out_i[i];
         assign out_pin_o[i] = pre ^ out_inv_i[i];
      end
   end
endmodule

// File: rtl/pin_ctl_unit.sv
module pin_ctl_unit
   import pin_ctl_pkg::*;
#(
   parameter int N_IN        = 4,
   parameter int N_OUT       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DW          = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_IN-1:0]  in_pin_i,
   input  logic             wp_pin_l_i,
   output logic [N_IN-1:0]  in_val_o,
   input  logic [N_OUT-1:0] int_out_i,
   output logic [N_OUT-1:0] out_pin_o,
   output logic             wp_out_l_o,
   input  logic             reg_wr_i,
   input  logic [2:0]       reg_addr_i,
   input  logic [DW-1:0]    reg_wdata_i,
   output logic [DW-1:0]    reg_rdata_o
);
   if (N_IN < 1 || N_IN + 1 > DW) begin : g_bad_nin
      $error("pin_ctl_unit: N_IN+1 must fit in DW");
   end
   if (N_OUT < 1 || N_OUT + 1 > DW) begin : g_bad_nout
      $error("pin_ctl_unit: N_OUT+1 must fit in DW");
   end

   logic [N_IN:0]    raw_sync;
   logic [N_IN-1:0]  in_inv;
   logic [N_OUT-1:0] out_inv;
   logic [N_OUT:0]   ovr_en, ovr_val, allow0, allow1;

   pin_sync #(.W(N_IN + 1), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({wp_pin_l_i, in_pin_i}),
      .q_o   (raw_sync)
   );

   assign in_val_o = raw_sync[N_IN-1:0] ^ in_inv;

   pin_cfg_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (reg_wr_i),
      .addr_i   (reg_addr_i),
      .wdata_i  (reg_wdata_i),
      .raw_i    (raw_sync),
      .in_inv_o (in_inv),
      .out_inv_o(out_inv),
      .ovr_en_o (ovr_en),
      .ovr_val_o(ovr_val),
      .allow0_o (allow0),
      .allow1_o (allow1),
      .rdata_o  (reg_rdata_o)
   );

   pin_out_mux #(.N_OUT(N_OUT)) u_mux (
      .int_out_i (int_out_i),
      .out_inv_i (out_inv),
      .ovr_en_i  (ovr_en),
      .ovr_val_i (ovr_val),
      .allow0_i  (allow0),
      .allow1_i  (allow1),
      .out_pin_o (out_pin_o),
      .wp_out_l_o(wp_out_l_o)
   );
endmodule

// File: rtl/pin_ctl_chk.sv
module pin_ctl_chk
   import pin_ctl_pkg::*;
#(
   parameter int N_IN  = 4,
   parameter int N_OUT = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             reg_wr_i,
   input logic [2:0]       reg_addr_i,
   input logic [N_IN-1:0]  raw_rd,
   input logic [N_IN-1:0]  in_val_o,
   input logic [N_IN-1:0]  in_inv_q,
   input logic [N_OUT-1:0] int_out_i,
   input logic [N_OUT-1:0] out_pin_o,
   input logic [N_OUT-1:0] out_inv_q,
   input logic [N_OUT:0]   ovr_en_q,
   input logic [N_OUT:0]   ovr_val_q,
   input logic [N_OUT:0]   allow1_q,
   input logic [N_OUT:0]   allow0_q,
   input logic             wp_out_l_o
);
   // R1
   always_comb begin
      if (!rst_ni) begin
         wp_reset_chk: assert (wp_out_l_o == 1'b0);
      end
   end

   // R2
   inval_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_addr_i == 3'(RA_RAW)) |-> ((raw_rd ^ in_inv_q) == in_val_o));

   // R4
   passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovr_en_q[N_OUT-1:0] == '0) |-> (out_pin_o == (int_out_i ^ out_inv_q)));

   // R7
   wp_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wp_out_l_o |-> (ovr_en_q[N_OUT] && ovr_val_q[N_OUT] && allow1_q[N_OUT]));

   // R7
   wp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_wr_i |=> $stable(wp_out_l_o));

   // R8
   cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!reg_wr_i || reg_addr_i == 3'(RA_RAW)) |=>
         $stable({in_inv_q, out_inv_q, ovr_en_q, ovr_val_q, allow0_q, allow1_q}));
endmodule

bind pin_ctl_unit pin_ctl_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .reg_wr_i  (reg_wr_i),
   .reg_addr_i(reg_addr_i),
   .raw_rd    (reg_rdata_o[N_IN-1:0]),
   .in_val_o  (in_val_o),
   .in_inv_q  (in_inv),
   .int_out_i (int_out_i),
   .out_pin_o (out_pin_o),
   .out_inv_q (out_inv),
   .ovr_en_q  (ovr_en),
   .ovr_val_q (ovr_val),
   .allow1_q  (allow1),
   .allow0_q  (allow0),
   .wp_out_l_o(wp_out_l_o)
);

// File: tb/tb_pin_ctl_unit.sv
module tb_pin_ctl_unit;
   localparam int NI = 4;
   localparam int NO = 4;
   localparam int SS = 2;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [NI-1:0] in_pin = '0;
   logic          wp_pin = 0;
   logic [NI-1:0] in_val;
   logic [NO-1:0] int_out = 4'hA;
   logic [NO-1:0] out_pin;
   logic          wp_out;
   logic          reg_wr = 0;
   logic [2:0]    reg_addr = 3'd0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   pin_ctl_unit #(.N_IN(NI), .N_OUT(NO), .SYNC_STAGES(SS), .DW(16)) dut (
      .clk_i(clk), .rst_ni(rst_n), .in_pin_i(in_pin), .wp_pin_l_i(wp_pin),
      .in_val_o(in_val), .int_out_i(int_out), .out_pin_o(out_pin),
      .wp_out_l_o(wp_out), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [NO:0] exp_out(input logic [NO:0] e, input logic [NO:0] v,
                                           input logic [NO:0] a0, input logic [NO:0] a1,
                                           input logic [NO-1:0] inv, input logic [NO-1:0] io);
      logic [NO:0] r;
      for (int i = 0; i <= NO; i++) begin
         logic t;
         t = e[i] & (v[i] ? a1[i] : a0[i]);
         if (i == NO) r[i] = t & v[i];
         else         r[i] = (t ? v[i] : io[i]) ^ inv[i];
      end
      return r;
   endfunction

   task automatic sweep_cfg(input logic [NO:0] e, input logic [NO:0] v,
                            input logic [NO:0] a0, input logic [NO:0] a1);
      wr(3'd2, 16'(e)); wr(3'd3, 16'(v)); wr(3'd4, 16'(a0)); wr(3'd5, 16'(a1));
      for (int k = 0; k < 2; k++) begin
         logic [NO-1:0] inv;
         inv = (k == 0) ? 4'h0 : 4'hF;
         wr(3'd1, 16'(inv));
         for (int io = 0; io < 16; io++) begin
            logic [NO:0] ex;
            @(negedge clk);
            int_out = 4'(io);
            wp_pin  = io[0] ^ io[2];
            ex = exp_out(e, v, a0, a1, inv, 4'(io));
            #1;
            // R4 R5 R6: override selection, allow masks, post-mux inversion
            chk("R4/R5/R6 out_pin", 32'(out_pin), 32'(ex[NO-1:0]));
            // R7: write-protect driven only by override, never by its pin
            chk("R7 wp_out", 32'(wp_out), 32'(ex[NO]));
         end
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      // R1: reset values while held in reset
      #1;
      chk("R1 out_pin in reset", 32'(out_pin), 32'hA);
      chk("R1 wp_out in reset", 32'(wp_out), 32'h0);
      rst_n = 1;
      @(negedge clk);
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d);
         chk($sformatf("R1 reg %0d after reset", a), 32'(d), 32'h0);
      end
      #1 chk("R1 wp_out after reset", 32'(wp_out), 32'h0);

      // R8: stored widths, unused bits read zero
      for (int a = 0; a < 6; a++) begin
         logic [15:0] m;
         wr(3'(a), 16'hFFFF);
         m = (a == 0) ? 16'h000F : (a == 1) ? 16'h000F : 16'h001F;
         rd(3'(a), d);
         chk($sformatf("R8 readback reg %0d", a), 32'(d), 32'(m));
      end
      // R8: write to raw address changes nothing
      wr(3'd6, 16'h0000);
      for (int a = 0; a < 6; a++) begin
         logic [15:0] m;
         m = (a < 2) ? 16'h000F : 16'h001F;
         rd(3'(a), d);
         chk($sformatf("R8 raw-address write ignored reg %0d", a), 32'(d), 32'(m));
      end
      #1 chk("R8 wp_out unchanged", 32'(wp_out), 32'h1);
      for (int a = 0; a < 6; a++) wr(3'(a), 16'h0000);

      // R2 R3: input sync latency, inversion, raw readback
      for (int p = 0; p < 16; p++) begin
         logic [NI-1:0] prev;
         wr(3'd0, 16'h0000);
         prev = in_val;
         @(negedge clk);
         in_pin = 4'(p);
         wp_pin = p[1];
         @(negedge clk);
         #1 chk("R2 not visible after one edge", 32'(in_val), 32'(prev));
         repeat (SS - 1) @(negedge clk);
         #1 chk("R2 visible after SYNC_STAGES edges", 32'(in_val), 32'(p));
         for (int inv = 0; inv < 16; inv++) begin
            wr(3'd0, 16'(inv));
            #1 chk("R2 inverted input", 32'(in_val), 32'(p ^ inv));
            rd(3'd6, d);
            // R3: bit N_IN holds write-protect pin, bits above zero
            chk("R3 raw readback", 32'(d), 32'({p[1], 4'(p)}));
         end
      end
      wr(3'd0, 16'h0000);

      // R4 R5 R6 R7: per-bit exhaustive over enable/value/allow0/allow1
      for (int c = 0; c < 16; c++) begin
         sweep_cfg({5{c[0]}}, {5{c[1]}}, {5{c[2]}}, {5{c[3]}});
      end
      // mixed per-bit patterns
      sweep_cfg(5'b10101, 5'b10011, 5'b01111, 5'b10001);
      sweep_cfg(5'b11111, 5'b01100, 5'b00110, 5'b11010);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule